// File: doc/BRIEF.md
# Microwire Serial Memory Device Engine

This block is the device end of a Microwire serial memory holding 16-bit words. A host drives chip select, a serial clock and a data line. The block decodes commands from that stream and answers on a data-out pin with an output enable, so that the pin can be tri-stated. The commands are a read that continues into the following words, a single-word write, a block write that fills 128 words with one value, and a pair of commands that arm and disarm a write-enable latch. A write that has been committed starts a self-timed program cycle. While that cycle runs, the block shows READY/BUSY on data-out whenever chip select is high.

The pins are sampled by a faster system clock through two-stage synchronizers, and every serial action is taken on a detected rising edge of the serial clock. The word array is a register file of 2^ADDR_W words. The length of the program cycle is the parameter PROG_CYCLES, counted in system clocks.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset every word reads FFFFh, the write-enable latch is clear, and the output enable is low.
- R2: A command starts at the first 1 sampled on a serial clock rise while chip select is high. Zeros before it are ignored.
- R3: Two opcode bits follow the start bit, MSB first: 10 is read, 01 is write, 00 is the extended group. In the extended group the two top address bits select the command: 11 sets the write-enable latch, 00 clears it, 01 is write-all. Address and data are shifted MSB first.
- R4: On a read, the rise that captures the last address bit drives a 0 on data-out. Each following rise drives the next bit of the addressed word, D15 first.
- R5: If clocking continues after the last bit of a word, the word at the next address follows without a gap. The address wraps from the top address to 0.
- R6: Write and write-all change nothing, and show no status, while the write-enable latch is clear. Read works whatever the latch holds.
- R7: A write commits only when chip select falls after the 29th rise counted from the start bit and before the 30th rise. A fall before the 29th rise, or a 30th rise, cancels the write.
- R8: Write-all stores one data word into all 128 words of the block that the low three address bits select. Words outside that block keep their values.
- R9: A commit starts a busy period of PROG_CYCLES system clocks. After a commit, while chip select is high, data-out is enabled and shows 0 while busy and 1 once ready. It keeps doing so until the next start bit is accepted.
- R10: A command sent while the busy period runs is ignored.
- R11: The output enable is low whenever chip select is low, and a low chip select returns the command logic to waiting for a start bit.
- R12: The disable command clears the write-enable latch, so later writes are ignored until the next enable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out and READY/BUSY status |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The assertions watch three things on every cycle. A low chip select returns the decoder to idle. A commit pulse follows only the armed state together with a chip-select fall. Each commit comes with the latch set and with no program cycle running, and it starts the busy period. What the array holds after a sequence can only be seen in the bench's scenarios, which compare every read word with a behavioural model. These scenarios cover the leading dummy bit, auto-increment with wrap-around, both cancel windows, the extent of a write-all block, and status that holds until the next start bit.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_OP, S_ADDR, S_DATA, S_ARMED, S_READ, S_DEAD
  } ustate_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_EXT   = 2'b00;

  localparam logic [1:0] EXT_WEN  = 2'b11;
  localparam logic [1:0] EXT_WDS  = 2'b00;
  localparam logic [1:0] EXT_WRAL = 2'b01;
endpackage

// File: rtl/uwire_sync.sv
module uwire_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        q[i]      <= meta_q[i];
      end
    end
  end
endmodule

// File: rtl/uwire_array.sv
module uwire_array #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int BLK_W       = 7,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_go,
  input  logic              wral_go,
  input  logic              wen,
  output logic              busy
);
  localparam int WORDS     = 1 << ADDR_W;
  localparam int BLK_WORDS = 1 << BLK_W;
  localparam int BSEL_W    = ADDR_W - BLK_W;
  localparam int TMR_W     = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [BSEL_W-1:0] bsel;

  assign bsel  = waddr[BSEL_W-1:0];
  assign rdata = mem[raddr];
  assign busy  = (tmr_q != '0);

  always_comb begin
    tmr_d = tmr_q;
    if (wr_go || wral_go) tmr_d = TMR_W'(PROG_CYCLES);
    else if (busy)        tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (wral_go) begin
      for (int i = 0; i < BLK_WORDS; i++) mem[{bsel, BLK_W'(i)}] <= wdata;
    end else if (wr_go) begin
      mem[waddr] <= wdata;
    end
  end

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go || wral_go) |=> busy);
  // R10
  no_go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wr_go || wral_go));
  // R6
  go_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go || wral_go) |-> wen);
endmodule

// File: rtl/uwire_cmd.sv
module uwire_cmd
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              wr_go,
  output logic              wral_go,
  output logic              wen,
  output logic              do_bit,
  output logic              do_oe
);
  localparam int CNT_W  = $clog2((ADDR_W > DATA_W) ? ADDR_W : DATA_W) + 1;
  localparam int RCNT_W = $clog2(DATA_W);

  ustate_t           state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_shift;
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic [DATA_W-1:0] rd_word_q, rd_word_d;
  logic [RCNT_W-1:0] rd_cnt_q, rd_cnt_d;
  logic              dbit_q, dbit_d, rd_on_q, rd_on_d;
  logic              stat_q, stat_d, wen_q, wen_d;
  logic              wr_go_q, wr_go_d, wral_go_q, wral_go_d;

  assign addr_shift = {addr_q[ADDR_W-2:0], di_s};
  assign raddr      = (state_q == S_ADDR) ? addr_shift : rd_addr_q + 1'b1;

  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;  op_d = op_q;
    addr_d = addr_q;    data_d = data_q;
    rd_addr_d = rd_addr_q;  rd_word_d = rd_word_q;  rd_cnt_d = rd_cnt_q;
    dbit_d = dbit_q;  rd_on_d = rd_on_q;  stat_d = stat_q;  wen_d = wen_q;
    wr_go_d = 1'b0;  wral_go_d = 1'b0;
    if (!cs_s) begin
      state_d = S_IDLE;
      rd_on_d = 1'b0;
      if (cs_fall && state_q == S_ARMED && wen_q) begin
        wr_go_d   = (op_q == OP_WRITE);
        wral_go_d = (op_q != OP_WRITE);
        stat_d    = 1'b1;
      end
    end else if (sk_rise) begin
      unique case (state_q)
        S_IDLE: if (di_s && !busy) begin
          state_d = S_OP;  cnt_d = '0;  stat_d = 1'b0;
        end
        S_OP: begin
          op_d = {op_q[0], di_s};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1)) begin state_d = S_ADDR; cnt_d = '0; end
        end
        S_ADDR: begin
          addr_d = addr_shift;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_W - 1)) begin
            cnt_d   = '0;
            state_d = S_DEAD;
            case (op_q)
              OP_READ: begin
                state_d = S_READ;  rd_addr_d = addr_shift;  rd_word_d = rdata;
                rd_cnt_d = '0;  dbit_d = 1'b0;  rd_on_d = 1'b1;
              end
              OP_WRITE: state_d = S_DATA;
              OP_EXT: case (addr_shift[ADDR_W-1 -: 2])
                EXT_WEN:  wen_d = 1'b1;
                EXT_WDS:  wen_d = 1'b0;
                EXT_WRAL: state_d = S_DATA;
                default:  state_d = S_DEAD;
              endcase
              default: state_d = S_DEAD;
            endcase
          end
        end
        S_DATA: begin
          data_d = {data_q[DATA_W-2:0], di_s};
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) state_d = S_ARMED;
        end
        S_READ: begin
          dbit_d = rd_word_q[DATA_W-1];
          if (rd_cnt_q == RCNT_W'(DATA_W - 1)) begin
            rd_cnt_d = '0;  rd_addr_d = raddr;  rd_word_d = rdata;
          end else begin
            rd_cnt_d = rd_cnt_q + 1'b1;  rd_word_d = rd_word_q << 1;
          end
        end
        default: state_d = S_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  cnt_q <= '0;  op_q <= '0;  addr_q <= '0;  data_q <= '0;
      rd_addr_q <= '0;  rd_word_q <= '0;  rd_cnt_q <= '0;  dbit_q <= 1'b0;
      rd_on_q <= 1'b0;  stat_q <= 1'b0;  wen_q <= 1'b0;
      wr_go_q <= 1'b0;  wral_go_q <= 1'b0;
    end else begin
      state_q <= state_d;  cnt_q <= cnt_d;  op_q <= op_d;  addr_q <= addr_d;
      data_q <= data_d;  rd_addr_q <= rd_addr_d;  rd_word_q <= rd_word_d;
      rd_cnt_q <= rd_cnt_d;  dbit_q <= dbit_d;  rd_on_q <= rd_on_d;
      stat_q <= stat_d;  wen_q <= wen_d;  wr_go_q <= wr_go_d;  wral_go_q <= wral_go_d;
    end
  end

  assign waddr   = addr_q;
  assign wdata   = data_q;
  assign wr_go   = wr_go_q;
  assign wral_go = wral_go_q;
  assign wen     = wen_q;
  assign do_oe   = cs_s && (rd_on_q || stat_q);
  assign do_bit  = rd_on_q ? dbit_q : !busy;

  // R11
  idle_on_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (state_q == S_IDLE));
  // R7
  commit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go_q || wral_go_q) |-> ($past(state_q) == S_ARMED) && !$past(cs_s));
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int BLK_W       = 7,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  logic              rst_m_q, rst_s_n;
  logic [2:0]        pins_s;
  logic              cs_s, sk_s, di_s, cs_d_q, sk_d_q;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;
  logic              wr_go, wral_go, wen, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_m_q <= 1'b0; rst_s_n <= 1'b0; end
    else        begin rst_m_q <= 1'b1; rst_s_n <= rst_m_q; end
  end

  uwire_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d({cs, sk, di}), .q(pins_s)
  );
  assign {cs_s, sk_s, di_s} = pins_s;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin cs_d_q <= 1'b0; sk_d_q <= 1'b0; end
    else          begin cs_d_q <= cs_s; sk_d_q <= sk_s; end
  end

  uwire_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_s_n), .cs_s(cs_s), .cs_fall(cs_d_q && !cs_s),
    .sk_rise(sk_s && !sk_d_q), .di_s(di_s), .busy(busy), .rdata(rdata),
    .raddr(raddr), .waddr(waddr), .wdata(wdata), .wr_go(wr_go),
    .wral_go(wral_go), .wen(wen), .do_bit(dout), .do_oe(dout_oe)
  );

  uwire_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
                .PROG_CYCLES(PROG_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_s_n), .raddr(raddr), .rdata(rdata), .waddr(waddr),
    .wdata(wdata), .wr_go(wr_go), .wral_go(wral_go), .wen(wen), .busy(busy)
  );
endmodule

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
  localparam int PROG = 1000;
  localparam int WORDS = 1024;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, dout_oe;
  int checks = 0, errors = 0;
  int ref_mem [WORDS];
  bit ref_wen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uwire_eeprom #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    di = b;
    repeat (4) @(negedge clk);
    sk = 1'b1;
    repeat (8) @(negedge clk);
    sk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input int val, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(val[i]);
  endtask

  task automatic cs_hi(); cs = 1'b1; repeat (4) @(negedge clk); endtask
  task automatic cs_lo(); cs = 1'b0; di = 1'b0; repeat (6) @(negedge clk); endtask
  task automatic wait_ready(); repeat (PROG + 20) @(negedge clk); endtask

  task automatic do_read(input int a, input int n, input int pad, input string req);
    int got;
    cs_hi();
    send(0, pad);
    send(3'b110, 3);
    send(a, 10);
    chk("R4 dummy oe", dout_oe, 1);
    chk("R4 dummy bit", dout, 0);
    for (int k = 0; k < n; k++) begin
      got = 0;
      for (int b = 0; b < 16; b++) begin
        clk_bit(1'b0);
        got = (got << 1) | int'(dout);
      end
      chk(req, got, ref_mem[(a + k) % WORDS]);
    end
    cs_lo();
    chk("R11 oe low", dout_oe, 0);
  endtask

  // mode 0: commit, 1: early fall, 2: extra rise
  task automatic wr_cmd(input int op, input int a, input int d, input int mode);
    cs_hi();
    send(1, 1);
    send(op, 2);
    send(a, 10);
    if (mode == 1) send(d >> 1, 15); else send(d, 16);
    if (mode == 2) clk_bit(1'b0);
    cs_lo();
    if (mode == 0 && ref_wen) begin
      if (op == 1) ref_mem[a] = d;
      else for (int i = 0; i < 128; i++) ref_mem[(a % 8) * 128 + i] = d;
    end
  endtask

  task automatic ext_cmd(input int code);
    cs_hi();
    send(3'b100, 3);
    send(code, 2);
    send(0, 8);
    cs_lo();
    if (code == 3) ref_wen = 1;
    if (code == 0) ref_wen = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    for (int i = 0; i < WORDS; i++) ref_mem[i] = 'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", dout_oe, 0);
    cs_hi();
    chk("R11 oe idle cs high", dout_oe, 0);
    cs_lo();
    do_read(0, 2, 0, "R1 reset word");

    // R6: write while latch clear is ignored, no status
    wr_cmd(1, 5, 'h1234, 0);
    cs_hi();
    chk("R6 no status", dout_oe, 0);
    cs_lo();
    do_read(5, 1, 0, "R6 ignored write");

    // R3 enable, R9 status
    ext_cmd(3);
    wr_cmd(1, 5, 'hA5C3, 0);
    cs_hi();
    chk("R9 busy oe", dout_oe, 1);
    chk("R9 busy bit", dout, 0);
    wait_ready();
    chk("R9 ready bit", dout, 1);
    chk("R9 ready oe", dout_oe, 1);
    clk_bit(1'b0);
    chk("R2 zero keeps status", dout_oe, 1);
    clk_bit(1'b1);
    chk("R9 start clears status", dout_oe, 0);
    cs_lo();

    // R2 padding zeros before start bit
    cs_hi();
    send(0, 3);
    cs = 1'b0; repeat (6) @(negedge clk);
    wr_cmd(1, 6, 'h0F0F, 0);
    wait_ready();
    do_read(4, 3, 4, "R5 R2 consecutive words");

    // R7 cancellation
    wr_cmd(1, 7, 'h5555, 1);
    cs_hi();
    chk("R7 early fall no status", dout_oe, 0);
    cs_lo();
    wr_cmd(1, 8, 'h6666, 2);
    cs_hi();
    chk("R7 extra rise no status", dout_oe, 0);
    cs_lo();
    do_read(7, 2, 0, "R7 cancelled word");

    // R5 wrap
    wr_cmd(1, 1023, 'hC001, 0);
    wait_ready();
    do_read(1023, 2, 0, "R5 wrap");

    // R10 command while busy ignored
    wr_cmd(1, 10, 'h1111, 0);
    cs_hi();
    bad = 0;
    send(1, 1); send(1, 2); send(11, 10);
    for (int i = 15; i >= 0; i--) begin
      clk_bit(1'b0);
      if (!dout_oe || dout) bad++;
    end
    chk("R10 status held busy", bad, 0);
    cs_lo();
    wait_ready();
    do_read(10, 2, 0, "R10 busy ignored");

    // R8 write-all block 2
    wr_cmd(0, 'h102, 'hBEEF, 0);
    wait_ready();
    do_read(255, 130, 0, "R8 block fill");

    // R12 disable
    ext_cmd(0);
    wr_cmd(1, 20, 'h7777, 0);
    cs_hi();
    chk("R12 no status", dout_oe, 0);
    cs_lo();
    wr_cmd(0, 'h100, 'h0, 0);
    do_read(20, 1, 0, "R12 write blocked");
    do_read(0, 1, 0, "R12 wral blocked");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule